// File: doc/BRIEF.md
# Dual-Width Arithmetic-Logic Slice

This block is a single-cycle arithmetic-logic slice serving one side of a datapath. Each of its two sources can be a 32-bit register value, a 40-bit register-pair value or a 5-bit signed immediate. The destination can be either 32 bits wide or 40 bits wide. It performs bitwise OR, addition and subtraction. Before the arithmetic, every source is brought to 40 bits with its sign. As a result, a 32-bit add or subtract that writes a 40-bit destination keeps the carry in the eight guard bits.

The caller places the operation, the kind of each source, both source buses and the destination size on the inputs and pulses `start`. One clock later the registered result appears with a valid flag, the destination size that was used, and a flag that marks an illegal size or code combination. Reading and writing the register file is done outside this block.

Top module: `dwalu_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `res_valid`, `res_illegal`, `res_wide` and `res_data` are all zero.
- R2: `res_valid` is high in exactly the cycles that follow a clock edge at which `start` was high.
- R3: Source kind 2 is an immediate. It is bits [4:0] of its source bus, sign-extended, so 5'b11011 acts as -5. Bits [39:5] of that bus are ignored.
- R4: Source kind 0 is a 32-bit register. It is bits [31:0] of its bus, sign-extended to 40 bits. Bits [39:32] of that bus are ignored.
- R5: With operation 1 (add) and `dst_wide` high, `res_data` is the 40-bit sum of the extended sources modulo 2^40. A carry out of bit 31 is therefore kept.
- R6: Operation 2 (subtract) gives source A minus source B: modulo 2^40 for a wide destination and modulo 2^32 for a narrow one.
- R7: With `dst_wide` low, `res_data[31:0]` holds the low 32 bits of the result and `res_data[39:32]` is zero.
- R8: Operation 0 (OR) is legal only with two sources of kind 0 or 2 and a narrow destination. In any other case `res_illegal` is set and `res_data` is zero.
- R9: These cases are also illegal, with `res_illegal` set and `res_data` zero: operation code 3, source kind 3, or an add or subtract that has a kind-1 (40-bit pair) source and a narrow destination.
- R10: `res_wide` returns the `dst_wide` value that was presented together with `start`.
- R11: In a cycle that follows an edge with `start` low, `res_data`, `res_wide` and `res_illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Takes in the operation this cycle |
| op_sel | input | 2 | 0 OR, 1 add, 2 subtract, 3 reserved |
| src_a_kind | input | 2 | 0 reg32, 1 pair40, 2 imm5, 3 reserved |
| src_a_data | input | 40 | Source A bus |
| src_b_kind | input | 2 | Same coding as `src_a_kind` |
| src_b_data | input | 40 | Source B bus |
| dst_wide | input | 1 | 1 selects a 40-bit destination |
| res_valid | output | 1 | Result valid |
| res_data | output | 40 | Result |
| res_illegal | output | 1 | Illegal combination flag |
| res_wide | output | 1 | Destination size of the result |

## Verification
In a single cycle, the sign extension of both sources and the width reduction of the destination both act on the same operation. An illegal-combination decision can also override both in that cycle. The bench provokes all of these together: it sweeps every operation code, every pair of source kinds and both destination sizes over source buses whose unused upper bits carry junk and whose used bits sit at the sign and carry boundaries. Each result is compared with a 40-bit model computed in the bench. In the cycle after each operation, the bench confirms that the valid flag drops and that the result holds.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;
  typedef enum logic [1:0] {
    OP_OR  = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_REG32 = 2'd0,
    K_PAIR  = 2'd1,
    K_IMM   = 2'd2,
    K_RSV   = 2'd3
  } kind_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/dwalu_operand_ext.sv
module dwalu_operand_ext
  import dwalu_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 40,
  parameter int unsigned IMM_W    = 5
) (
  input  kind_e              kind,
  input  logic [WIDE_W-1:0]  raw,
  output logic [WIDE_W-1:0]  ext,
  output logic               is_pair,
  output logic               bad_kind
);
  localparam int unsigned GUARD_W = WIDE_W - NARROW_W;
  localparam int unsigned IFILL_W = WIDE_W - IMM_W;

  always_comb begin
    ext      = '0;
    is_pair  = 1'b0;
    bad_kind = 1'b0;
    unique case (kind)
      K_REG32: ext = {{GUARD_W{raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
      K_PAIR: begin
        ext     = raw;
        is_pair = 1'b1;
      end
      K_IMM:   ext = {{IFILL_W{raw[IMM_W-1]}}, raw[IMM_W-1:0]};
      default: bad_kind = 1'b1;
    endcase
  end

  // R3/R4: a short source never sets the guard bits to anything but its sign
  always_comb begin
    if (kind == K_REG32)
      a_r4_sign_fill: assert (ext[WIDE_W-1:NARROW_W] == {GUARD_W{ext[NARROW_W-1]}});
    if (kind == K_IMM)
      a_r3_imm_fill: assert (ext[WIDE_W-1:IMM_W] == {IFILL_W{ext[IMM_W-1]}});
  end
endmodule

// File: rtl/dwalu_legal.sv
module dwalu_legal
  import dwalu_pkg::*;
(
  input  op_e                 op,
  input  logic [NUM_SRC-1:0]  src_pair,
  input  logic [NUM_SRC-1:0]  src_bad,
  input  logic                dst_wide,
  output logic                illegal
);
  logic any_pair;
  logic any_bad;

  assign any_pair = |src_pair;
  assign any_bad  = |src_bad;

  always_comb begin
    illegal = any_bad;
    unique case (op)
      OP_OR:   if (any_pair || dst_wide) illegal = 1'b1;
      OP_ADD,
      OP_SUB:  if (any_pair && !dst_wide) illegal = 1'b1;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dwalu_core.sv
module dwalu_core
  import dwalu_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 40
) (
  input  op_e                op,
  input  logic [WIDE_W-1:0]  opa,
  input  logic [WIDE_W-1:0]  opb,
  input  logic               dst_wide,
  output logic [WIDE_W-1:0]  result
);
  localparam int unsigned GUARD_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0] full;

  always_comb begin
    unique case (op)
      OP_OR:   full = opa | opb;
      OP_ADD:  full = opa + opb;
      OP_SUB:  full = opa - opb;
      default: full = '0;
    endcase
  end

  assign result = dst_wide ? full : {{GUARD_W{1'b0}}, full[NARROW_W-1:0]};
endmodule

// File: rtl/dwalu_top.sv
module dwalu_top
  import dwalu_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 40,
  parameter int unsigned IMM_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        src_a_kind,
  input  logic [WIDE_W-1:0] src_a_data,
  input  logic [1:0]        src_b_kind,
  input  logic [WIDE_W-1:0] src_b_data,
  input  logic              dst_wide,
  output logic              res_valid,
  output logic [WIDE_W-1:0] res_data,
  output logic              res_illegal,
  output logic              res_wide
);
  localparam int unsigned GUARD_W = WIDE_W - NARROW_W;

  kind_e             kinds [NUM_SRC];
  logic [WIDE_W-1:0] raws  [NUM_SRC];
  logic [WIDE_W-1:0] exts  [NUM_SRC];
  logic [NUM_SRC-1:0] pair_v;
  logic [NUM_SRC-1:0] bad_v;

  assign kinds[0] = kind_e'(src_a_kind);
  assign kinds[1] = kind_e'(src_b_kind);
  assign raws[0]  = src_a_data;
  assign raws[1]  = src_b_data;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    dwalu_operand_ext #(
      .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .IMM_W(IMM_W)
    ) u_ext (
      .kind     (kinds[s]),
      .raw      (raws[s]),
      .ext      (exts[s]),
      .is_pair  (pair_v[s]),
      .bad_kind (bad_v[s])
    );
  end

  op_e               op;
  logic              illegal_c;
  logic [WIDE_W-1:0] result_c;

  assign op = op_e'(op_sel);

  dwalu_legal u_legal (
    .op       (op),
    .src_pair (pair_v),
    .src_bad  (bad_v),
    .dst_wide (dst_wide),
    .illegal  (illegal_c)
  );

  dwalu_core #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_core (
    .op       (op),
    .opa      (exts[0]),
    .opb      (exts[1]),
    .dst_wide (dst_wide),
    .result   (result_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_illegal <= 1'b0;
      res_wide    <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_data    <= illegal_c ? '0 : result_c;
        res_illegal <= illegal_c;
        res_wide    <= dst_wide;
      end
    end
  end

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid);
  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> (res_data == '0));
  a_r7_narrow_guard_clear: assert property (@(posedge clk) disable iff (rst)
    !res_wide |-> (res_data[WIDE_W-1:NARROW_W] == {GUARD_W{1'b0}}));
  a_r10_wide_echo: assert property (@(posedge clk) disable iff (rst)
    start |=> (res_wide == $past(dst_wide)));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(res_data) && $stable(res_illegal) && $stable(res_wide)));
endmodule

// File: tb/sim_dwalu_top.sv
module sim_dwalu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [1:0]  src_a_kind = '0;
  logic [39:0] src_a_data = '0;
  logic [1:0]  src_b_kind = '0;
  logic [39:0] src_b_data = '0;
  logic        dst_wide = 1'b0;
  logic        res_valid;
  logic [39:0] res_data;
  logic        res_illegal;
  logic        res_wide;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwalu_top u0 (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
    .src_a_kind(src_a_kind), .src_a_data(src_a_data),
    .src_b_kind(src_b_kind), .src_b_data(src_b_data),
    .dst_wide(dst_wide), .res_valid(res_valid), .res_data(res_data),
    .res_illegal(res_illegal), .res_wide(res_wide)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h op=%0d ka=%0d kb=%0d wide=%0d",
               req, act, exp, op_sel, src_a_kind, src_b_kind, dst_wide);
    end
  endtask

  function automatic logic [39:0] ext(input logic [1:0] k, input logic [39:0] d);
    case (k)
      2'd0:    return {{8{d[31]}}, d[31:0]};
      2'd1:    return d;
      2'd2:    return {{35{d[4]}}, d[4:0]};
      default: return '0;
    endcase
  endfunction

  function automatic logic model_illegal(input logic [1:0] op, input logic [1:0] ka,
                                         input logic [1:0] kb, input logic w);
    logic pair = (ka == 2'd1) || (kb == 2'd1);
    if (op == 2'd3 || ka == 2'd3 || kb == 2'd3) return 1'b1;  // R9
    if (op == 2'd0) return pair || w;                          // R8
    return pair && !w;                                         // R9
  endfunction

  function automatic logic [39:0] model_data(input logic [1:0] op, input logic [1:0] ka,
      input logic [39:0] a, input logic [1:0] kb, input logic [39:0] b, input logic w);
    logic [39:0] x = ext(ka, a);
    logic [39:0] y = ext(kb, b);
    logic [39:0] r;
    if (model_illegal(op, ka, kb, w)) return '0;
    case (op)
      2'd0:    r = x | y;
      2'd1:    r = x + y;
      default: r = x - y;
    endcase
    return w ? r : {8'h00, r[31:0]};
  endfunction

  function automatic string tag(input logic [1:0] op, input logic [1:0] ka,
                                input logic [1:0] kb, input logic w);
    if (model_illegal(op, ka, kb, w)) return (op == 2'd0) ? "R8" : "R9";
    if (ka == 2'd2 || kb == 2'd2) return "R3";
    if (op == 2'd0) return "R8";
    if (op == 2'd2) return "R6";
    if (!w) return "R7";
    if (ka == 2'd0 || kb == 2'd0) return "R4";
    return "R5";
  endfunction

  localparam logic [39:0] PA [6] = '{40'h00_7FFF_FFFF, 40'hA5_8000_0000, 40'h3C_FFFF_FFF1,
                                     40'h00_0000_0005, 40'hFF_FFFF_FFFF, 40'h80_0000_001B};
  localparam logic [39:0] PB [6] = '{40'h00_0000_0001, 40'h5A_8000_0000, 40'h12_0000_001B,
                                     40'h7F_FFFF_FFFF, 40'hC3_1234_5678, 40'h00_FFFF_FFF0};

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", {36'b0, res_valid, res_illegal, res_wide, 1'b0}, '0);
    check("R1", res_data, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {37'b0, res_valid, res_illegal, res_wide}, '0);
    check("R1", res_data, '0);

    for (int op = 0; op < 4; op++)
      for (int ka = 0; ka < 4; ka++)
        for (int kb = 0; kb < 4; kb++)
          for (int w = 0; w < 2; w++)
            for (int i = 0; i < 6; i++)
              for (int j = 0; j < 6; j++) begin
                op_sel = op[1:0]; src_a_kind = ka[1:0]; src_b_kind = kb[1:0];
                dst_wide = w[0]; src_a_data = PA[i]; src_b_data = PB[j];
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R2", {39'b0, res_valid}, 40'd1);
                check("R10", {39'b0, res_wide}, {39'b0, w[0]});
                check(model_illegal(op[1:0], ka[1:0], kb[1:0], w[0]) ? "R9" : "R8",
                      {39'b0, res_illegal},
                      {39'b0, model_illegal(op[1:0], ka[1:0], kb[1:0], w[0])});
                check(tag(op[1:0], ka[1:0], kb[1:0], w[0]), res_data,
                      model_data(op[1:0], ka[1:0], PA[i], kb[1:0], PB[j], w[0]));
                held = res_data;
                // change inputs without start: R11 says nothing moves
                src_a_data = ~src_a_data; op_sel = ~op_sel; dst_wide = ~dst_wide;
                @(negedge clk);
                check("R2", {39'b0, res_valid}, 40'd0);
                check("R11", res_data, held);
              end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule